// File: doc/BRIEF.md
# Cascaded Clock-Stage Reset Sequencer

This block brings up a chain of two clock-synthesis stages in which the second stage is fed by the output of the first. It runs on a free-running reference clock and produces one reset for each stage, a reset for the rest of the logic, and a flag that says the whole chain is usable. The external active-low reset and both lock indicators are brought into the reference domain through two flip-flop stages before the block acts on them.

After a power-up hold, the first stage is let out of reset. The second stage stays in reset until the first stage reports lock, plus a programmable settling delay. The logic reset is removed only after the second stage reports lock and a second programmable delay has passed. A stage that fails to lock within a timeout is not left alone: the sequencer pulses every reset for a minimum width and starts again from the first stage. A lost lock sends the sequence back to the matching waiting point.

Top module: `ckseq_chain_rst`

## Requirements
- R1: While `ext_rst_n` is low, `stage_a_rst`, `stage_b_rst` and `logic_rst` are 1 and `chain_ready` is 0, and they take these values as soon as `ext_rst_n` falls, without waiting for a clock edge.
- R2: After `ext_rst_n` rises (with both locks low), `stage_a_rst` falls on reference edge 3 + max(2^POR_W, PULSE_MIN-1), counting the first edge after the rise as 1.
- R3: `stage_b_rst` stays 1 for as long as the synchronised first-stage lock is 0.
- R4: When `lock_a` rises while the first stage is waiting, `stage_b_rst` falls on edge 3 + POST_LOCK_DLY after the rise (2 sync edges, 1 detect edge, then the delay).
- R5: When `lock_b` rises while the second stage is waiting, `logic_rst` falls and `chain_ready` rises on edge 3 + LOGIC_DLY after the rise.
- R6: If the first stage does not lock, `stage_a_rst` rises again exactly LOCK_TMO edges after it fell.
- R7: A retry holds `stage_a_rst` high for exactly PULSE_MIN edges (power-up hold already done), then releases it to wait for first-stage lock again.
- R8: If the second stage does not lock, `stage_a_rst` and `stage_b_rst` both rise exactly LOCK_TMO edges after `stage_b_rst` fell; with `lock_a` still high, `stage_b_rst` then falls POST_LOCK_DLY+1 edges after `stage_a_rst` falls.
- R9: When `lock_a` falls at any later point, `stage_b_rst` and `logic_rst` are 1 and `chain_ready` is 0 within 3 edges, and the block waits for first-stage lock again.
- R10: When `lock_b` falls while running, `logic_rst` rises and `chain_ready` falls within 3 edges while `stage_a_rst` and `stage_b_rst` stay 0.
- R11: `chain_ready` is 1 only when all three resets are 0; `stage_b_rst` is never 0 while `stage_a_rst` is 1, and `logic_rst` is never 0 while `stage_b_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| lock_a | input | 1 | Lock indicator of the first clock stage, asynchronous |
| lock_b | input | 1 | Lock indicator of the second clock stage, asynchronous |
| stage_a_rst | output | 1 | Reset to the first clock stage, active high |
| stage_b_rst | output | 1 | Reset to the second clock stage, active high |
| logic_rst | output | 1 | Reset to the logic clocked by the synthesised clock, active high |
| chain_ready | output | 1 | High while the chain is fully up and the logic is out of reset |

## Verification
The hardest situations to reach are the two timeout retries, because they need a stage that never locks while the other one behaves. The stimulus holds `lock_a` low for a whole timeout window and then, in a second pass, raises `lock_a` but keeps `lock_b` low until the second-stage window expires. With a short timeout parameter the bench then measures the exact edge of each reassertion, the retry pulse width and the fast restart that follows when the first lock is already present.

// File: rtl/ckseq_pkg.sv
package ckseq_pkg;

    typedef enum logic [2:0] {
        ST_RESET_ALL   = 3'd0,
        ST_WAIT_LOCK1  = 3'd1,
        ST_DELAY2      = 3'd2,
        ST_WAIT_LOCK2  = 3'd3,
        ST_DELAY_LOGIC = 3'd4,
        ST_RUN         = 3'd5
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ckseq_rst_sync.sv
module ckseq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ckseq_sync.sv
module ckseq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] ff_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= {ff_q[STAGES-2:0], din[b]};
        end
        assign dout[b] = ff_q[STAGES-1];
    end
endmodule

// File: rtl/ckseq_por.sv
module ckseq_por #(
    parameter int POR_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    logic [POR_W:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!cnt_q[POR_W]) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = cnt_q[POR_W];
endmodule

// File: rtl/ckseq_fsm.sv
module ckseq_fsm
    import ckseq_pkg::*;
#(
    parameter int LOCK_TMO      = 65535,
    parameter int PULSE_MIN     = 16,
    parameter int POST_LOCK_DLY = 8,
    parameter int LOGIC_DLY     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_done,
    input  logic lk_a,
    input  logic lk_b,
    output logic a_rst,
    output logic b_rst,
    output logic l_rst,
    output logic ready
);
    localparam int unsigned MAXV  = max2(max2(LOCK_TMO, PULSE_MIN), max2(POST_LOCK_DLY, LOGIC_DLY));
    localparam int          CNT_W = $clog2(MAXV + 1);
    localparam logic [CNT_W-1:0] TMO_END   = CNT_W'(LOCK_TMO - 1);
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_MIN - 1);
    localparam logic [CNT_W-1:0] PD_END    = CNT_W'(POST_LOCK_DLY - 1);
    localparam logic [CNT_W-1:0] LD_END    = CNT_W'(LOGIC_DLY - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             a_rst;
        logic             b_rst;
        logic             l_rst;
        logic             ready;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{st: ST_RESET_ALL, cnt: '0,
                                        a_rst: 1'b1, b_rst: 1'b1, l_rst: 1'b1, ready: 1'b0};

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_RESET_ALL: begin
                if (seq_q.cnt == PULSE_END) begin
                    if (por_done) begin
                        seq_d.st  = ST_WAIT_LOCK1;
                        seq_d.cnt = '0;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_WAIT_LOCK1: begin
                seq_d.cnt = '0;
                if (lk_a)                        seq_d.st = ST_DELAY2;
                else if (seq_q.cnt == TMO_END)   seq_d.st = ST_RESET_ALL;
                else                             seq_d.cnt = seq_q.cnt + 1'b1;
            end
            ST_DELAY2: begin
                seq_d.cnt = '0;
                if (!lk_a)                       seq_d.st = ST_WAIT_LOCK1;
                else if (seq_q.cnt == PD_END)    seq_d.st = ST_WAIT_LOCK2;
                else                             seq_d.cnt = seq_q.cnt + 1'b1;
            end
            ST_WAIT_LOCK2: begin
                seq_d.cnt = '0;
                if (!lk_a)                       seq_d.st = ST_WAIT_LOCK1;
                else if (lk_b)                   seq_d.st = ST_DELAY_LOGIC;
                else if (seq_q.cnt == TMO_END)   seq_d.st = ST_RESET_ALL;
                else                             seq_d.cnt = seq_q.cnt + 1'b1;
            end
            ST_DELAY_LOGIC: begin
                seq_d.cnt = '0;
                if (!lk_a)                       seq_d.st = ST_WAIT_LOCK1;
                else if (!lk_b)                  seq_d.st = ST_WAIT_LOCK2;
                else if (seq_q.cnt == LD_END)    seq_d.st = ST_RUN;
                else                             seq_d.cnt = seq_q.cnt + 1'b1;
            end
            ST_RUN: begin
                seq_d.cnt = '0;
                if (!lk_a)                       seq_d.st = ST_WAIT_LOCK1;
                else if (!lk_b)                  seq_d.st = ST_WAIT_LOCK2;
            end
            default: begin
                seq_d.st  = ST_RESET_ALL;
                seq_d.cnt = '0;
            end
        endcase

        seq_d.a_rst = (seq_d.st == ST_RESET_ALL);
        seq_d.b_rst = (seq_d.st == ST_RESET_ALL) || (seq_d.st == ST_WAIT_LOCK1) ||
                      (seq_d.st == ST_DELAY2);
        seq_d.l_rst = (seq_d.st != ST_RUN);
        seq_d.ready = (seq_d.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= RESET_VAL;
        else        seq_q <= seq_d;
    end

    assign a_rst = seq_q.a_rst;
    assign b_rst = seq_q.b_rst;
    assign l_rst = seq_q.l_rst;
    assign ready = seq_q.ready;
endmodule

// File: rtl/ckseq_chain_rst.sv
module ckseq_chain_rst #(
    parameter int LOCK_TMO      = 65535,
    parameter int PULSE_MIN     = 16,
    parameter int POST_LOCK_DLY = 8,
    parameter int LOGIC_DLY     = 8,
    parameter int POR_W         = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_ref,
    input  logic ext_rst_n,
    input  logic lock_a,
    input  logic lock_b,
    output logic stage_a_rst,
    output logic stage_b_rst,
    output logic logic_rst,
    output logic chain_ready
);
    logic       rst_n_int;
    logic       por_done;
    logic [1:0] lock_s;

    ckseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk    (clk_ref),
        .arst_n (ext_rst_n),
        .rst_n  (rst_n_int)
    );

    ckseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_lsync (
        .clk   (clk_ref),
        .rst_n (rst_n_int),
        .din   ({lock_b, lock_a}),
        .dout  (lock_s)
    );

    ckseq_por #(.POR_W(POR_W)) u_por (
        .clk   (clk_ref),
        .rst_n (rst_n_int),
        .done  (por_done)
    );

    ckseq_fsm #(
        .LOCK_TMO      (LOCK_TMO),
        .PULSE_MIN     (PULSE_MIN),
        .POST_LOCK_DLY (POST_LOCK_DLY),
        .LOGIC_DLY     (LOGIC_DLY)
    ) u_fsm (
        .clk      (clk_ref),
        .rst_n    (rst_n_int),
        .por_done (por_done),
        .lk_a     (lock_s[0]),
        .lk_b     (lock_s[1]),
        .a_rst    (stage_a_rst),
        .b_rst    (stage_b_rst),
        .l_rst    (logic_rst),
        .ready    (chain_ready)
    );
endmodule

// File: rtl/ckseq_chain_rst_chk.sv
module ckseq_chain_rst_chk (
    input logic clk,
    input logic rst_n,
    input logic lock_s_a,
    input logic stage_a_rst,
    input logic stage_b_rst,
    input logic logic_rst,
    input logic chain_ready
);
    // R11
    ready_only_when_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_ready |-> (!stage_a_rst && !stage_b_rst && !logic_rst));

    // R11
    b_after_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_b_rst |-> !stage_a_rst);

    // R11
    logic_after_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !logic_rst |-> !stage_b_rst);

    // R3
    b_held_without_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_s_a |=> stage_b_rst);

    // R4
    b_release_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stage_b_rst) |-> ($past(lock_s_a) && $past(lock_s_a, 2)));

    // R7
    retry_resets_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_a_rst) |-> (stage_b_rst && logic_rst && !chain_ready));
endmodule

bind ckseq_chain_rst ckseq_chain_rst_chk u_chk (
    .clk         (clk_ref),
    .rst_n       (rst_n_int),
    .lock_s_a    (lock_s[0]),
    .stage_a_rst (stage_a_rst),
    .stage_b_rst (stage_b_rst),
    .logic_rst   (logic_rst),
    .chain_ready (chain_ready)
);

// File: tb/ckseq_chain_rst_tb.sv
module ckseq_chain_rst_tb_top;
    localparam int  TMO    = 40;
    localparam int  PULSE  = 4;
    localparam int  PDLY   = 5;
    localparam int  LDLY   = 3;
    localparam int  PORW   = 3;
    localparam time TCLK   = 8ns;

    logic clk_ref = 1'b0;
    logic ext_rst_n = 1'b0;
    logic lock_a = 1'b0;
    logic lock_b = 1'b0;
    logic stage_a_rst, stage_b_rst, logic_rst, chain_ready;

    int n_checks = 0;
    int n_fails  = 0;

    always #(TCLK/2) clk_ref = ~clk_ref;

    ckseq_chain_rst #(
        .LOCK_TMO(TMO), .PULSE_MIN(PULSE), .POST_LOCK_DLY(PDLY),
        .LOGIC_DLY(LDLY), .POR_W(PORW), .SYNC_STAGES(2)
    ) dut_i (
        .clk_ref     (clk_ref),
        .ext_rst_n   (ext_rst_n),
        .lock_a      (lock_a),
        .lock_b      (lock_b),
        .stage_a_rst (stage_a_rst),
        .stage_b_rst (stage_b_rst),
        .logic_rst   (logic_rst),
        .chain_ready (chain_ready)
    );

    // expected bits are {stage_a_rst, stage_b_rst, logic_rst, chain_ready}
    typedef struct packed {
        logic       la;
        logic       lb;
        logic [7:0] edges;
        logic [3:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b0, 8'd20, 4'b0110, 8'd3},   // R3: first stage released, second held
        '{1'b1, 1'b0, 8'd12, 4'b0010, 8'd4},   // R4: second stage released after delay
        '{1'b1, 1'b1, 8'd10, 4'b0001, 8'd5},   // R5: logic released, ready
        '{1'b1, 1'b0, 8'd6,  4'b0010, 8'd10},  // R10: second lock lost
        '{1'b1, 1'b1, 8'd10, 4'b0001, 8'd5},   // R5: running again
        '{1'b0, 1'b1, 8'd4,  4'b0110, 8'd9},   // R9: first lock lost
        '{1'b1, 1'b1, 8'd14, 4'b0001, 8'd4}    // R4: full re-lock
    };

    function automatic logic [3:0] outs();
        return {stage_a_rst, stage_b_rst, logic_rst, chain_ready};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // sel: 0 stage_a_rst, 1 stage_b_rst, 2 logic_rst
    task automatic edges_until(input int sel, input logic val, output int n);
        logic s;
        n = 0;
        for (int i = 1; i <= 2000; i++) begin
            @(posedge clk_ref); #1;
            s = (sel == 0) ? stage_a_rst : (sel == 1) ? stage_b_rst : logic_rst;
            if (s === val) begin
                n = i;
                return;
            end
        end
        n = -1;
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        #(TCLK * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(negedge clk_ref);
        check("R1 reset outputs", int'(outs()), int'(4'b1110));

        @(negedge clk_ref) ext_rst_n = 1'b1;
        for (int v = 0; v < 7; v++) begin
            @(negedge clk_ref);
            lock_a = VECS[v].la;
            lock_b = VECS[v].lb;
            repeat (int'(VECS[v].edges)) @(posedge clk_ref);
            #1;
            check($sformatf("R%0d table row %0d", VECS[v].req, v), int'(outs()), int'(VECS[v].exp));
        end

        // R1: asynchronous assertion mid-run
        @(negedge clk_ref);
        #1 ext_rst_n = 1'b0;
        #1 check("R1 async reset", int'(outs()), int'(4'b1110));
        lock_a = 1'b0;
        lock_b = 1'b0;
        repeat (3) @(negedge clk_ref);

        // R2: power-up hold
        ext_rst_n = 1'b1;
        edges_until(0, 1'b0, n);
        check("R2 first stage release edge", n, 3 + imax(1 << PORW, PULSE - 1));

        // R6: first-stage timeout
        edges_until(0, 1'b1, n);
        check("R6 first-stage timeout", n, TMO);
        check("R6 all resets on retry", int'(outs()), int'(4'b1110));

        // R7: retry pulse width
        edges_until(0, 1'b0, n);
        check("R7 retry pulse width", n, PULSE);

        // R4: post-lock delay
        @(negedge clk_ref) lock_a = 1'b1;
        edges_until(1, 1'b0, n);
        check("R4 second stage release edge", n, 3 + PDLY);

        // R8: second-stage timeout restarts from the first stage
        edges_until(1, 1'b1, n);
        check("R8 second-stage timeout", n, TMO);
        check("R8 first stage reset too", int'(stage_a_rst), 1);
        edges_until(0, 1'b0, n);
        check("R7 pulse after second timeout", n, PULSE);
        edges_until(1, 1'b0, n);
        check("R8 fast restart with lock present", n, PDLY + 1);

        // R5: logic release delay
        @(negedge clk_ref) lock_b = 1'b1;
        edges_until(2, 1'b0, n);
        check("R5 logic release edge", n, 3 + LDLY);
        check("R5 ready with logic release", int'(chain_ready), 1);

        // R10 then R9 from running
        @(negedge clk_ref) lock_b = 1'b0;
        repeat (3) @(posedge clk_ref);
        #1 check("R10 second lock lost", int'(outs()), int'(4'b0010));
        @(negedge clk_ref) lock_a = 1'b0;
        repeat (3) @(posedge clk_ref);
        #1 check("R9 first lock lost", int'(outs()), int'(4'b0110));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule